// File: doc/BRIEF.md
# Five-Stage In-Order Load/Store Core

This block is a small in-order processor core. It splits every instruction over five clocked stages: fetch, decode, execute, memory access and register write-back. Each stage hands its results to the next through its own pipeline register. The core accepts a new instruction on every clock, so up to five instructions are in flight at once. It runs a four-instruction subset on an eight-entry register file: add, nand, load word and store word. It holds its instruction store and data store as word arrays. Both arrays are filled through preload ports while reset is held, and both can be read out through peek ports.

The core has no branches, no stall logic and no forwarding between stages. Software must keep a consumer at least three instruction slots behind its producer. This works because a register written in write-back is visible to the decode read in the same cycle. After the last real instruction, all-zero words are fetched. They travel down the pipeline as bubbles and drain it.

Top module: `lsp_core`

## Requirements
- R1: While reset is high, on each clock edge the fetch address is set to 0, every inter-stage register is set to a bubble, and all eight registers are set to 0. As a result, `retire_valid` reads 0.
- R2: After reset is released, the fetch address increases by 4 on every clock. The instruction word fetched comes from entry `fetch_pc[IM_AW+1:2]`.
- R3: An add has bits [31:26]=0 and bits [5:0]=0x20. It writes the sum of the rs register (bits [25:21]) and the rt register (bits [20:16]) into the rd register (bits [15:11]).
- R4: A nand has bits [31:26]=0 and bits [5:0]=0x27. It writes the bitwise NOT of (rs AND rt) into rd.
- R5: A load has bits [31:26]=0x23. It writes the data word at byte address rs + immediate into rt. The word index is taken from address bits [DM_AW+1:2].
- R6: A store has bits [31:26]=0x2B. It writes the rt value to the data word at byte address rs + immediate. It leaves every register unchanged.
- R7: Any other encoding acts as a bubble. It changes no register and no data word.
- R8: Only the low 3 bits of each register field select a register. Register 0 is an ordinary writable register.
- R9: An instruction fetched exactly three slots after its producer reads the producer's new value.
- R10: The 16-bit immediate (bits [15:0]) is sign-extended before the address add.
- R11: Take the clock edge that fetches an instruction. The fourth edge after it presents the instruction's result on `retire_dest`/`retire_data` with `retire_valid` high. The register file shows the new value one edge later.
- R12: `retire_valid` is high only for add, nand and load. Once the program ends, it stays low after the last of these has left the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_load_en | input | 1 | Write enable for the instruction store |
| imem_load_addr | input | IM_AW | Instruction store word index |
| imem_load_data | input | 32 | Instruction word to write |
| dmem_load_en | input | 1 | Write enable for the data store (takes priority over a store instruction) |
| dmem_load_addr | input | DM_AW | Data store word index |
| dmem_load_data | input | 32 | Data word to write |
| reg_peek_idx | input | 3 | Register to read out |
| reg_peek_data | output | 32 | Current value of that register |
| dmem_peek_addr | input | DM_AW | Data word to read out |
| dmem_peek_data | output | 32 | Current value of that data word |
| fetch_pc | output | 32 | Current fetch byte address |
| retire_valid | output | 1 | A register write is happening this cycle |
| retire_dest | output | 3 | Register being written |
| retire_data | output | 32 | Value being written |

## Verification
A fault in an inter-stage register surfaces on the retire port exactly four clocks after the faulty instruction was fetched. It shows as a wrong destination, a wrong value, or a valid pulse on a bubble or store. The register file peek shows the same damage one clock later. A broken store path does not show on the retire port. It shows in the data-store peek, and in the register loaded later from that word. The bench also records the retire port and the fetch address on every cycle, which catches a pipeline that is one stage too short or too long.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int IMM_W  = 16;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] FN_NAND   = 6'h27;

    typedef enum logic [2:0] {
        K_NOP   = 3'd0,
        K_ADD   = 3'd1,
        K_NAND  = 3'd2,
        K_LOAD  = 3'd3,
        K_STORE = 3'd4
    } kind_e;

    typedef struct packed {
        logic [XLEN-1:0] insn;
        logic [XLEN-1:0] pc_next;
    } fd_reg_t;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] dest;
        logic [XLEN-1:0]   imm;
        logic [XLEN-1:0]   opa;
        logic [XLEN-1:0]   opb;
        logic [XLEN-1:0]   pc_next;
    } dx_reg_t;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] dest;
        logic [XLEN-1:0]   result;
        logic [XLEN-1:0]   sdata;
    } xm_reg_t;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] dest;
        logic [XLEN-1:0]   result;
        logic [XLEN-1:0]   ldata;
    } mw_reg_t;

    function automatic logic kind_writes_reg(kind_e k);
        return (k == K_ADD) || (k == K_NAND) || (k == K_LOAD);
    endfunction
endpackage

// File: rtl/lsp_fetch.sv
module lsp_fetch
    import lsp_pkg::*;
#(
    parameter int IM_DEPTH = 64,
    localparam int IM_AW   = $clog2(IM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [IM_AW-1:0] load_addr,
    input  logic [XLEN-1:0]  load_data,
    output logic [XLEN-1:0]  pc_o,
    output fd_reg_t          fd_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        fd_reg_t         fd;
    } fetch_st_t;

    logic [XLEN-1:0] istore [IM_DEPTH];
    fetch_st_t st_d, st_q;
    logic unused_pc_bits;

    assign unused_pc_bits = ^{st_q.pc[XLEN-1:IM_AW+2], st_q.pc[1:0]};

    always_comb begin
        st_d            = st_q;
        st_d.pc         = st_q.pc + XLEN'(4);
        st_d.fd.insn    = istore[st_q.pc[IM_AW+1:2]];
        st_d.fd.pc_next = st_q.pc + XLEN'(4);
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (load_en) istore[load_addr] <= load_data;
    end

    assign pc_o = st_q.pc;
    assign fd_o = st_q.fd;

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> st_q.pc == $past(st_q.pc) + XLEN'(4));
endmodule

// File: rtl/lsp_decode.sv
module lsp_decode
    import lsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fd_reg_t           fd_i,
    input  logic              wb_we,
    input  logic [RIDX_W-1:0] wb_idx,
    input  logic [XLEN-1:0]   wb_data,
    input  logic [RIDX_W-1:0] peek_idx,
    output logic [XLEN-1:0]   peek_data,
    output dx_reg_t           dx_o
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
        dx_reg_t                   dx;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [5:0]        opc, fn;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx;
    kind_e             kind;
    logic              unused_insn;

    assign opc    = fd_i.insn[31:26];
    assign fn     = fd_i.insn[5:0];
    assign rs_idx = fd_i.insn[21 +: RIDX_W];
    assign rt_idx = fd_i.insn[16 +: RIDX_W];
    assign rd_idx = fd_i.insn[11 +: RIDX_W];
    assign unused_insn = ^fd_i.insn;

    // Write-back lands first: a same-cycle read of the written index sees new data.
    function automatic logic [XLEN-1:0] rf_read(logic [RIDX_W-1:0] idx,
                                                logic [NREG-1:0][XLEN-1:0] arr,
                                                logic we, logic [RIDX_W-1:0] widx,
                                                logic [XLEN-1:0] wdat);
        return (we && widx == idx) ? wdat : arr[idx];
    endfunction

    always_comb begin
        kind = K_NOP;
        if (opc == OPC_REG && fn == FN_ADD)       kind = K_ADD;
        else if (opc == OPC_REG && fn == FN_NAND) kind = K_NAND;
        else if (opc == OPC_LOAD)                 kind = K_LOAD;
        else if (opc == OPC_STORE)                kind = K_STORE;
    end

    always_comb begin
        st_d = st_q;
        if (wb_we) st_d.regs[wb_idx] = wb_data;
        st_d.dx = '0;
        if (kind != K_NOP) begin
            st_d.dx.kind    = kind;
            st_d.dx.dest    = (kind == K_LOAD) ? rt_idx :
                              (kind == K_STORE) ? '0 : rd_idx;
            st_d.dx.imm     = {{(XLEN-IMM_W){fd_i.insn[IMM_W-1]}}, fd_i.insn[IMM_W-1:0]};
            st_d.dx.opa     = rf_read(rs_idx, st_q.regs, wb_we, wb_idx, wb_data);
            st_d.dx.opb     = rf_read(rt_idx, st_q.regs, wb_we, wb_idx, wb_data);
            st_d.dx.pc_next = fd_i.pc_next;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dx_o      = st_q.dx;
    assign peek_data = st_q.regs[peek_idx];

    p_wb_lands_r9: assert property (@(posedge clk) disable iff (rst)
        wb_we |=> st_q.regs[$past(wb_idx)] == $past(wb_data));
endmodule

// File: rtl/lsp_execute.sv
module lsp_execute
    import lsp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  dx_reg_t dx_i,
    output xm_reg_t xm_o
);
    xm_reg_t xm_d, xm_q;
    logic    unused_link;

    assign unused_link = ^dx_i.pc_next;

    always_comb begin
        xm_d = '0;
        if (dx_i.kind != K_NOP) begin
            xm_d.kind  = dx_i.kind;
            xm_d.dest  = dx_i.dest;
            xm_d.sdata = dx_i.opb;
            unique case (dx_i.kind)
                K_ADD:   xm_d.result = dx_i.opa + dx_i.opb;
                K_NAND:  xm_d.result = ~(dx_i.opa & dx_i.opb);
                default: xm_d.result = dx_i.opa + dx_i.imm;
            endcase
        end
        if (rst) xm_d = '0;
    end

    always_ff @(posedge clk) begin
        xm_q <= xm_d;
    end

    assign xm_o = xm_q;

    p_stage_order_r11: assert property (@(posedge clk) disable iff (rst)
        !rst |=> xm_q.kind == $past(dx_i.kind) && xm_q.dest == $past(dx_i.dest));
endmodule

// File: rtl/lsp_memory.sv
module lsp_memory
    import lsp_pkg::*;
#(
    parameter int DM_DEPTH = 64,
    localparam int DM_AW   = $clog2(DM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  xm_reg_t          xm_i,
    input  logic             load_en,
    input  logic [DM_AW-1:0] load_addr,
    input  logic [XLEN-1:0]  load_data,
    input  logic [DM_AW-1:0] peek_addr,
    output logic [XLEN-1:0]  peek_data,
    output mw_reg_t          mw_o
);
    logic [XLEN-1:0]  dstore [DM_DEPTH];
    logic [DM_AW-1:0] widx;
    mw_reg_t          mw_d, mw_q;
    logic             unused_addr_bits;

    assign widx             = xm_i.result[DM_AW+1:2];
    assign unused_addr_bits = ^{xm_i.result[XLEN-1:DM_AW+2], xm_i.result[1:0]};

    always_comb begin
        mw_d = '0;
        if (xm_i.kind != K_NOP) begin
            mw_d.kind   = xm_i.kind;
            mw_d.dest   = xm_i.dest;
            mw_d.result = xm_i.result;
            mw_d.ldata  = (xm_i.kind == K_LOAD) ? dstore[widx] : '0;
        end
        if (rst) mw_d = '0;
    end

    always_ff @(posedge clk) begin
        mw_q <= mw_d;
        if (load_en)                     dstore[load_addr] <= load_data;
        else if (xm_i.kind == K_STORE)   dstore[widx]      <= xm_i.sdata;
    end

    assign mw_o      = mw_q;
    assign peek_data = dstore[peek_addr];

    p_store_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (xm_i.kind == K_STORE && !load_en) |=> dstore[$past(widx)] == $past(xm_i.sdata));

    p_bubble_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (xm_i.kind == K_NOP) |=> (mw_q.dest == '0 && mw_q.result == '0 && mw_q.kind == K_NOP));
endmodule

// File: rtl/lsp_core.sv
module lsp_core
    import lsp_pkg::*;
#(
    parameter int IM_DEPTH = 64,
    parameter int DM_DEPTH = 64,
    localparam int IM_AW   = $clog2(IM_DEPTH),
    localparam int DM_AW   = $clog2(DM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imem_load_en,
    input  logic [IM_AW-1:0]  imem_load_addr,
    input  logic [31:0]       imem_load_data,
    input  logic              dmem_load_en,
    input  logic [DM_AW-1:0]  dmem_load_addr,
    input  logic [31:0]       dmem_load_data,
    input  logic [2:0]        reg_peek_idx,
    output logic [31:0]       reg_peek_data,
    input  logic [DM_AW-1:0]  dmem_peek_addr,
    output logic [31:0]       dmem_peek_data,
    output logic [31:0]       fetch_pc,
    output logic              retire_valid,
    output logic [2:0]        retire_dest,
    output logic [31:0]       retire_data
);
    fd_reg_t fd;
    dx_reg_t dx;
    xm_reg_t xm;
    mw_reg_t mw;
    logic              wb_we;
    logic [XLEN-1:0]   wb_data;

    lsp_fetch #(.IM_DEPTH(IM_DEPTH)) i_fetch (
        .clk(clk), .rst(rst),
        .load_en(imem_load_en), .load_addr(imem_load_addr), .load_data(imem_load_data),
        .pc_o(fetch_pc), .fd_o(fd)
    );

    lsp_decode i_decode (
        .clk(clk), .rst(rst), .fd_i(fd),
        .wb_we(wb_we), .wb_idx(mw.dest), .wb_data(wb_data),
        .peek_idx(reg_peek_idx), .peek_data(reg_peek_data),
        .dx_o(dx)
    );

    lsp_execute i_execute (
        .clk(clk), .rst(rst), .dx_i(dx), .xm_o(xm)
    );

    lsp_memory #(.DM_DEPTH(DM_DEPTH)) i_memory (
        .clk(clk), .rst(rst), .xm_i(xm),
        .load_en(dmem_load_en), .load_addr(dmem_load_addr), .load_data(dmem_load_data),
        .peek_addr(dmem_peek_addr), .peek_data(dmem_peek_data),
        .mw_o(mw)
    );

    // Write-back: choose the loaded word or the computed value.
    always_comb begin
        wb_we   = kind_writes_reg(mw.kind);
        wb_data = (mw.kind == K_LOAD) ? mw.ldata : mw.result;
    end

    assign retire_valid = wb_we;
    assign retire_dest  = mw.dest;
    assign retire_data  = wb_data;
endmodule

// File: tb/test_lsp_core.sv
`timescale 1ns/1ps
module test_lsp_core;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_load_en = 1'b0;
    logic [5:0]  imem_load_addr = '0;
    logic [31:0] imem_load_data = '0;
    logic        dmem_load_en = 1'b0;
    logic [5:0]  dmem_load_addr = '0;
    logic [31:0] dmem_load_data = '0;
    logic [2:0]  reg_peek_idx = '0;
    logic [31:0] reg_peek_data;
    logic [5:0]  dmem_peek_addr = '0;
    logic [31:0] dmem_peek_data;
    logic [31:0] fetch_pc;
    logic        retire_valid;
    logic [2:0]  retire_dest;
    logic [31:0] retire_data;

    lsp_core i_lsp_core (
        .clk(clk), .rst(rst),
        .imem_load_en(imem_load_en), .imem_load_addr(imem_load_addr), .imem_load_data(imem_load_data),
        .dmem_load_en(dmem_load_en), .dmem_load_addr(dmem_load_addr), .dmem_load_data(dmem_load_data),
        .reg_peek_idx(reg_peek_idx), .reg_peek_data(reg_peek_data),
        .dmem_peek_addr(dmem_peek_addr), .dmem_peek_data(dmem_peek_data),
        .fetch_pc(fetch_pc), .retire_valid(retire_valid),
        .retire_dest(retire_dest), .retire_data(retire_data)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;

    logic [31:0] prog  [DEPTH];
    logic [31:0] dinit [DEPTH];
    int          plen;
    logic        tr_rv   [32];
    logic [2:0]  tr_dest [32];
    logic [31:0] tr_data [32];
    logic [31:0] tr_pc   [32];
    logic [31:0] mregs   [8];
    logic [31:0] mmem    [DEPTH];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] op_r(input logic [5:0] fn, input logic [4:0] rd,
                                         input logic [4:0] rs, input logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] op_i(input logic [5:0] opc, input logic [4:0] rt,
                                         input logic [4:0] rs, input logic [15:0] imm);
        return {opc, rs, rt, imm};
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < DEPTH; i++) begin
            prog[i]  = '0;
            dinit[i] = '0;
        end
        plen = 0;
    endtask

    task automatic put(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    // Reference: execute the program one instruction at a time.
    task automatic model_run();
        logic [31:0] w, a, b, imm, addr;
        for (int r = 0; r < 8; r++) mregs[r] = '0;
        for (int i = 0; i < DEPTH; i++) mmem[i] = dinit[i];
        for (int i = 0; i < plen; i++) begin
            w   = prog[i];
            a   = mregs[w[23:21]];
            b   = mregs[w[18:16]];
            imm = {{16{w[15]}}, w[15:0]};
            addr = a + imm;
            if (w[31:26] == 6'h00 && w[5:0] == 6'h20)      mregs[w[13:11]] = a + b;
            else if (w[31:26] == 6'h00 && w[5:0] == 6'h27) mregs[w[13:11]] = ~(a & b);
            else if (w[31:26] == 6'h23)                    mregs[w[18:16]] = mmem[addr[7:2]];
            else if (w[31:26] == 6'h2B)                    mmem[addr[7:2]] = b;
        end
    endtask

    task automatic boot();
        rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            imem_load_en = 1'b1; imem_load_addr = 6'(i); imem_load_data = prog[i];
            dmem_load_en = 1'b1; dmem_load_addr = 6'(i); dmem_load_data = dinit[i];
        end
        @(negedge clk);
        imem_load_en = 1'b0;
        dmem_load_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_prog();
        boot();
        rst = 1'b0;
        for (int k = 1; k <= plen + 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            tr_rv[k]   = retire_valid;
            tr_dest[k] = retire_dest;
            tr_data[k] = retire_data;
            tr_pc[k]   = fetch_pc;
        end
    endtask

    task automatic compare_state(input string req);
        model_run();
        for (int r = 0; r < 8; r++) begin
            reg_peek_idx = 3'(r);
            #0.1;
            chk(reg_peek_data === mregs[r], req, reg_peek_data, mregs[r]);
        end
        for (int m = 0; m < DEPTH; m++) begin
            dmem_peek_addr = 6'(m);
            #0.1;
            chk(dmem_peek_data === mmem[m], req, dmem_peek_data, mmem[m]);
        end
    endtask

    task automatic t_reset_r1();
        clear_prog();
        put(op_i(6'h23, 5'd1, 5'd0, 16'd0));
        dinit[0] = 32'h1234_5678;
        run_prog();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(fetch_pc == 32'd0, "R1 pc", fetch_pc, 32'd0);
        chk(retire_valid == 1'b0, "R1 retire", 32'(retire_valid), 32'd0);
        for (int r = 0; r < 8; r++) begin
            reg_peek_idx = 3'(r);
            #0.1;
            chk(reg_peek_data == 32'd0, "R1 regs", reg_peek_data, 32'd0);
        end
    endtask

    task automatic t_basic();
        clear_prog();
        dinit[0] = 32'd8;
        dinit[1] = 32'h0000_0022;
        dinit[2] = 32'hF0F0_1234;
        dinit[3] = 32'h0FF0_FF00;
        dinit[4] = 32'h1111_1111;
        put(op_i(6'h23, 5'd1, 5'd0, 16'd0));
        put(op_i(6'h23, 5'd2, 5'd0, 16'd4));
        put(op_i(6'h23, 5'd3, 5'd0, 16'd8));
        put(op_i(6'h23, 5'd4, 5'd0, 16'd12));
        put(32'h0);
        put(op_r(6'h20, 5'd5, 5'd1, 5'd2));
        put(op_r(6'h27, 5'd6, 5'd3, 5'd4));
        put(op_i(6'h23, 5'd7, 5'd1, 16'd8));
        put(32'h0);
        put(32'h0);
        put(op_i(6'h2B, 5'd5, 5'd0, 16'd20));
        put(op_i(6'h2B, 5'd6, 5'd1, 16'd24));
        put(op_r(6'h20, 5'd0, 5'd5, 5'd7));
        run_prog();
        for (int k = 1; k <= 6; k++)
            chk(tr_pc[k] == 32'(4 * k), "R2 pc step", tr_pc[k], 32'(4 * k));
        chk(tr_rv[3] == 1'b0, "R11 early", 32'(tr_rv[3]), 32'd0);
        chk(tr_rv[4] == 1'b1 && tr_dest[4] == 3'd1 && tr_data[4] == 32'd8,
            "R11 retire", tr_data[4], 32'd8);
        compare_state("R3 R4 R5 R6 program");
        reg_peek_idx = 3'd6;
        #0.1;
        chk(reg_peek_data == ~(32'hF0F0_1234 & 32'h0FF0_FF00), "R4 nand", reg_peek_data,
            ~(32'hF0F0_1234 & 32'h0FF0_FF00));
        dmem_peek_addr = 6'd5;
        #0.1;
        chk(dmem_peek_data == 32'h2A, "R6 store", dmem_peek_data, 32'h2A);
    endtask

    task automatic t_ignored_r7();
        int n_rv;
        clear_prog();
        dinit[0] = 32'h55;
        dinit[1] = 32'h66;
        put(op_i(6'h23, 5'd1, 5'd0, 16'd0));
        put(op_i(6'h23, 5'd2, 5'd0, 16'd4));
        put(32'h0);
        put(32'h0);
        put(op_i(6'h3F, 5'd1, 5'd0, 16'd5));
        put(op_r(6'h21, 5'd2, 5'd1, 5'd1));
        put(op_i(6'h2A, 5'd1, 5'd0, 16'd48));
        put(op_i(6'h2B, 5'd1, 5'd0, 16'd40));
        run_prog();
        compare_state("R7 unknown encodings");
        n_rv = 0;
        for (int k = 1; k <= plen + 6; k++) n_rv += int'(tr_rv[k]);
        chk(n_rv == 2, "R12 retire count", 32'(n_rv), 32'd2);
    endtask

    task automatic t_fields_r8();
        clear_prog();
        dinit[0] = 32'd5;
        put(op_i(6'h23, 5'd1, 5'd0, 16'd0));
        put(32'h0);
        put(32'h0);
        put(op_r(6'h20, 5'd10, 5'd9, 5'd17));
        put(32'h0);
        put(32'h0);
        put(op_r(6'h20, 5'd8, 5'd2, 5'd2));
        run_prog();
        compare_state("R8 fields");
        reg_peek_idx = 3'd0;
        #0.1;
        chk(reg_peek_data == 32'd20, "R8 r0 writable", reg_peek_data, 32'd20);
    endtask

    task automatic t_wbr_r9();
        clear_prog();
        dinit[0] = 32'd7;
        put(op_i(6'h23, 5'd1, 5'd0, 16'd0));
        put(32'h0);
        put(32'h0);
        put(op_r(6'h20, 5'd2, 5'd1, 5'd1));
        put(32'h0);
        put(32'h0);
        put(op_r(6'h20, 5'd3, 5'd2, 5'd1));
        run_prog();
        compare_state("R9 three slots");
        reg_peek_idx = 3'd3;
        #0.1;
        chk(reg_peek_data == 32'd21, "R9 chained", reg_peek_data, 32'd21);
    endtask

    task automatic t_negimm_r10();
        clear_prog();
        dinit[0]  = 32'd64;
        dinit[15] = 32'h0000_ABCD;
        put(op_i(6'h23, 5'd1, 5'd0, 16'd0));
        put(32'h0);
        put(32'h0);
        put(op_i(6'h23, 5'd2, 5'd1, 16'hFFFC));
        put(32'h0);
        put(32'h0);
        put(op_i(6'h2B, 5'd2, 5'd1, 16'hFFF8));
        run_prog();
        compare_state("R10 negative offset");
        dmem_peek_addr = 6'd14;
        #0.1;
        chk(dmem_peek_data == 32'h0000_ABCD, "R10 store", dmem_peek_data, 32'h0000_ABCD);
    endtask

    task automatic t_drain_r12();
        clear_prog();
        dinit[0] = 32'd9;
        put(op_i(6'h23, 5'd1, 5'd0, 16'd0));
        put(32'h0);
        put(32'h0);
        put(op_r(6'h20, 5'd2, 5'd1, 5'd1));
        run_prog();
        chk(tr_rv[7] == 1'b1 && tr_dest[7] == 3'd2 && tr_data[7] == 32'd18,
            "R11 last retire", tr_data[7], 32'd18);
        for (int k = 8; k <= 10; k++)
            chk(tr_rv[k] == 1'b0, "R12 drained", 32'(tr_rv[k]), 32'd0);
        compare_state("R12 final");
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_basic();
        t_ignored_r7();
        t_fields_r8();
        t_wbr_r9();
        t_negimm_r10();
        t_drain_r12();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule